// File: doc/BRIEF.md
# Eight-bit Sixteen-Function Arithmetic Logic Unit

This block is the combinational arithmetic and logic stage of a small 8-bit datapath. It takes two operands. One is the bus operand `opd_d`. The other is a second operand `opd_e`, which normally comes from a temporary register. A 4-bit function code picks one of sixteen operations. A 2-bit select picks the carry fed into the arithmetic and shift operations. That carry can be a fixed 0 or 1, the carry flag held elsewhere in the datapath (`c_stored`), or the inverse of that flag.

The operations fall into five groups:
- Constant outputs.
- A pass-through of the second operand.
- Two's-complement style negation with a carry adjust.
- Bitwise logic.
- Addition and subtraction forms, and three single-bit shifts.

Each operation has its own carry and overflow rule. All outputs settle in the same cycle as the inputs. No state is held.

Top module: `alu8_core`

## Requirements
- R1: The carry used by the operations follows `cin_sel`: 0 gives 0, 1 gives 1, 2 gives `c_stored`, and 3 gives the inverse of `c_stored`.
- R2: Function codes 0, 1, 2 and 3 drive the result with all zeros, all ones except bit 1, all ones except bit 0, and all ones (0x00, 0xFD, 0xFE, 0xFF).
- R3: Function code 4 drives the result with `opd_e` unchanged.
- R4: Function code 5 drives the result with the bitwise inverse of `opd_d` plus the carry, modulo 256. V is 1 exactly when `opd_d` is 0x80. C is 1 exactly when `opd_d` is nonzero.
- R5: Function codes 6, 7 and 8 drive the result with D OR E, D AND E and D XOR E respectively.
- R6: Function code 9 gives D plus carry, and code 10 gives D plus 0xFF. For both, C is bit 8 of the 9-bit sum. For code 9, V is set when D is non-negative and the result is negative. For code 10, V is set when D is negative and the result is non-negative.
- R7: Function code 11 gives D+E+carry. C is bit 8 of the sum. V is set when D and E have the same sign and the result sign differs from it.
- R8: Function code 12 gives D−E−carry modulo 256. C is 1 when E+carry exceeds D (a borrow). V is set when D and E differ in sign and the result sign differs from D.
- R9: Function code 13 shifts D left by one with the carry entering bit 0. C is the old bit 7. V is C XOR the new bit 7.
- R10: Function code 14 shifts D right with the carry entering bit 7. Code 15 shifts D right keeping bit 7. In both, C is the old bit 0 and V is C XOR the new bit 7.
- R11: `flags` is packed as bit 3 = N (result bit 7), bit 2 = Z (result is zero), bit 1 = V, bit 0 = C.
- R12: For function codes 0–4 and 6–8, V and C are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_d | input | 8 | Bus operand D |
| opd_e | input | 8 | Second operand E |
| func | input | 4 | Operation select, codes 0–15 |
| cin_sel | input | 2 | Carry source select |
| c_stored | input | 1 | Carry flag held by the datapath |
| result | output | 8 | Operation result |
| flags | output | 4 | {N, Z, V, C} |

## Verification
Both `result` and `flags` are pure functions of the present inputs, so every result is due in the same cycle the stimulus is applied, with zero register stages. The bench applies each input set one time unit after a rising clock edge and samples at the next falling edge. This leaves half a period for settling and keeps every comparison clear of the edge. Expected values come from a bench model written with integer arithmetic. That model is checked on random vectors and on directed corner values: 0x00, 0x7F, 0x80 and 0xFF, each under every carry select.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    FN_ZERO  = 4'd0,
    FN_KFD   = 4'd1,
    FN_KFE   = 4'd2,
    FN_ONES  = 4'd3,
    FN_PASSE = 4'd4,
    FN_NEG   = 4'd5,
    FN_OR    = 4'd6,
    FN_AND   = 4'd7,
    FN_XOR   = 4'd8,
    FN_INC   = 4'd9,
    FN_DEC   = 4'd10,
    FN_ADC   = 4'd11,
    FN_SBC   = 4'd12,
    FN_SHL   = 4'd13,
    FN_SHR   = 4'd14,
    FN_ASR   = 4'd15
  } alu_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO  = 2'd0,
    CI_ONE   = 2'd1,
    CI_FLAG  = 2'd2,
    CI_NFLAG = 2'd3
  } cin_src_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  // Operation group of a function code.
  function automatic logic fn_is_arith(input alu_fn_e f);
    return (f == FN_NEG) || (f == FN_INC) || (f == FN_DEC) ||
           (f == FN_ADC) || (f == FN_SBC);
  endfunction

  function automatic logic fn_is_shift(input alu_fn_e f);
    return (f == FN_SHL) || (f == FN_SHR) || (f == FN_ASR);
  endfunction

endpackage

// File: rtl/alu8_cin_mux.sv
module alu8_cin_mux
  import alu8_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       c_stored,
  output logic       cin
);
  always_comb begin
    unique case (cin_src_e'(sel))
      CI_ZERO:  cin = 1'b0;
      CI_ONE:   cin = 1'b1;
      CI_FLAG:  cin = c_stored;
      CI_NFLAG: cin = ~c_stored;
      default:  cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   func,
  input  logic [W-1:0] d,
  input  logic [W-1:0] e,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] K_ZERO = '0;
  localparam logic [W-1:0] K_ONES = '1;
  localparam logic [W-1:0] K_FD   = ~W'(2);
  localparam logic [W-1:0] K_FE   = ~W'(1);

  always_comb begin
    unique case (alu_fn_e'(func))
      FN_ZERO:  res = K_ZERO;
      FN_KFD:   res = K_FD;
      FN_KFE:   res = K_FE;
      FN_ONES:  res = K_ONES;
      FN_PASSE: res = e;
      FN_OR:    res = d | e;
      FN_AND:   res = d & e;
      FN_XOR:   res = d ^ e;
      default:  res = K_ZERO;
    endcase
  end
endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   func,
  input  logic [W-1:0] d,
  input  logic [W-1:0] e,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         v
);
  localparam int      SW   = W + 1;
  localparam int      MSB  = W - 1;
  localparam logic [W-1:0] SIGN = W'(1) << MSB;

  // Sum helpers, carry or borrow lands in bit W.
  function automatic logic [SW-1:0] add3(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic ci);
    return {1'b0, a} + {1'b0, b} + SW'(ci);
  endfunction

  function automatic logic [SW-1:0] sub3(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic ci);
    return {1'b0, a} - ({1'b0, b} + SW'(ci));
  endfunction

  logic [SW-1:0] s_inc, s_dec, s_adc, s_sbc;
  logic [W-1:0]  neg_res;

  assign s_inc   = add3(d, '0, cin);
  assign s_dec   = add3(d, '1, 1'b0);
  assign s_adc   = add3(d, e, cin);
  assign s_sbc   = sub3(d, e, cin);
  assign neg_res = ~d + W'(cin);

  always_comb begin
    res = '0;
    c   = 1'b0;
    v   = 1'b0;
    unique case (alu_fn_e'(func))
      FN_NEG: begin
        res = neg_res;
        v   = (d == SIGN);
        c   = (d != '0);
      end
      FN_INC: begin
        res = s_inc[W-1:0];
        c   = s_inc[W];
        v   = ~d[MSB] & s_inc[MSB];
      end
      FN_DEC: begin
        res = s_dec[W-1:0];
        c   = s_dec[W];
        v   = d[MSB] & ~s_dec[MSB];
      end
      FN_ADC: begin
        res = s_adc[W-1:0];
        c   = s_adc[W];
        v   = (d[MSB] == e[MSB]) & (s_adc[MSB] != d[MSB]);
      end
      FN_SBC: begin
        res = s_sbc[W-1:0];
        c   = s_sbc[W];
        v   = (d[MSB] != e[MSB]) & (s_sbc[MSB] != d[MSB]);
      end
      default: begin
        res = '0;
        c   = 1'b0;
        v   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_shift_unit.sv
module alu8_shift_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   func,
  input  logic [W-1:0] d,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         v
);
  localparam int MSB = W - 1;

  always_comb begin
    res = '0;
    c   = 1'b0;
    unique case (alu_fn_e'(func))
      FN_SHL: begin
        res = {d[MSB-1:0], cin};
        c   = d[MSB];
      end
      FN_SHR: begin
        res = {cin, d[MSB:1]};
        c   = d[0];
      end
      FN_ASR: begin
        res = {d[MSB], d[MSB:1]};
        c   = d[0];
      end
      default: begin
        res = '0;
        c   = 1'b0;
      end
    endcase
    v = c ^ res[MSB];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opd_d,
  input  logic [W-1:0] opd_e,
  input  logic [3:0]   func,
  input  logic [1:0]   cin_sel,
  input  logic         c_stored,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  localparam int MSB = W - 1;

  // Named internal events, visible to the checker.
  logic         cin_used;
  logic [W-1:0] res_logic, res_arith, res_shift;
  logic         c_arith, v_arith, c_shift, v_shift;
  logic         grp_arith, grp_shift;
  alu_flags_t   fl;

  alu8_cin_mux u_cin (
    .sel      (cin_sel),
    .c_stored (c_stored),
    .cin      (cin_used)
  );

  alu8_logic_unit #(.W(W)) u_logic (
    .func (func),
    .d    (opd_d),
    .e    (opd_e),
    .res  (res_logic)
  );

  alu8_arith_unit #(.W(W)) u_arith (
    .func (func),
    .d    (opd_d),
    .e    (opd_e),
    .cin  (cin_used),
    .res  (res_arith),
    .c    (c_arith),
    .v    (v_arith)
  );

  alu8_shift_unit #(.W(W)) u_shift (
    .func (func),
    .d    (opd_d),
    .cin  (cin_used),
    .res  (res_shift),
    .c    (c_shift),
    .v    (v_shift)
  );

  assign grp_arith = fn_is_arith(alu_fn_e'(func));
  assign grp_shift = fn_is_shift(alu_fn_e'(func));

  always_comb begin
    if (grp_shift) begin
      result = res_shift;
      fl.c   = c_shift;
      fl.v   = v_shift;
    end else if (grp_arith) begin
      result = res_arith;
      fl.c   = c_arith;
      fl.v   = v_arith;
    end else begin
      result = res_logic;
      fl.c   = 1'b0;
      fl.v   = 1'b0;
    end
    fl.n = result[MSB];
    fl.z = (result == '0);
  end

  assign flags = fl;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] opd_d,
  input logic [W-1:0] opd_e,
  input logic [3:0]   func,
  input logic [1:0]   cin_sel,
  input logic         c_stored,
  input logic [W-1:0] result,
  input logic [3:0]   flags,
  input logic         cin_used
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] SIGN = W'(1) << MSB;

  always_comb begin
    if (func <= 4'd3) begin
      assert_const_out_R2: assert (result == (func == 4'd0 ? W'(0) :
                                               func == 4'd3 ? ~W'(0) :
                                               func == 4'd1 ? ~W'(2) : ~W'(1)));
    end
    if (func == 4'd4) begin
      assert_pass_e_R3: assert (result == opd_e);
    end
    if (func == 4'd5) begin
      assert_neg_flags_R4: assert (flags[1] == (opd_d == SIGN) && flags[0] == (opd_d != '0));
    end
    if (func <= 4'd4 || (func >= 4'd6 && func <= 4'd8)) begin
      assert_quiet_vc_R12: assert (flags[1:0] == 2'b00);
    end
    if (func >= 4'd13) begin
      assert_shift_v_R9: assert (flags[1] == (flags[0] ^ result[MSB]));
    end
    if (func == 4'd9 && opd_d == '0) begin
      assert_cin_pick_R1: assert (result == W'(cin_sel == 2'd1 ||
                                               (cin_sel == 2'd2 && c_stored) ||
                                               (cin_sel == 2'd3 && !c_stored)));
    end
    if (func == 4'd14) begin
      assert_shr_top_R10: assert (result[MSB] == cin_used);
    end
  end
endmodule

bind alu8_core alu8_checker #(.W(W)) u_chk (
  .opd_d    (opd_d),
  .opd_e    (opd_e),
  .func     (func),
  .cin_sel  (cin_sel),
  .c_stored (c_stored),
  .result   (result),
  .flags    (flags),
  .cin_used (cin_used)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opd_d, opd_e;
  logic [3:0] func;
  logic [1:0] cin_sel;
  logic       c_stored;
  logic [7:0] result;
  logic [3:0] flags;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  alu8_core dut (
    .opd_d    (opd_d),
    .opd_e    (opd_e),
    .func     (func),
    .cin_sel  (cin_sel),
    .c_stored (c_stored),
    .result   (result),
    .flags    (flags)
  );

  // Requirement tag for each function code.
  function automatic string tag_of(input int f);
    case (f)
      0, 1, 2, 3: return "R2";
      4:          return "R3";
      5:          return "R4";
      6, 7, 8:    return "R5";
      9, 10:      return "R6";
      11:         return "R7";
      12:         return "R8";
      13:         return "R9";
      default:    return "R10";
    endcase
  endfunction

  // Reference model in plain integers: returns {N,Z,V,C,result}.
  function automatic logic [11:0] ref_alu(input int d, input int e, input int f,
                                          input int sel, input int cs);
    int ci, u, t, c, v;
    case (sel)
      0: ci = 0;
      1: ci = 1;
      2: ci = cs;
      default: ci = 1 - cs;
    endcase
    c = 0; v = 0; u = 0;
    case (f)
      0: u = 0;
      1: u = 253;
      2: u = 254;
      3: u = 255;
      4: u = e;
      5: begin u = (255 - d + ci) % 256; v = (d == 128); c = (d != 0); end
      6: u = d | e;
      7: u = d & e;
      8: u = d ^ e;
      9: begin t = d + ci; u = t % 256; c = (t > 255); v = (d < 128 && u >= 128); end
      10: begin t = d + 255; u = t % 256; c = (t > 255); v = (d >= 128 && u < 128); end
      11: begin
        t = d + e + ci; u = t % 256; c = (t > 255);
        v = ((d >= 128) == (e >= 128)) && ((u >= 128) != (d >= 128));
      end
      12: begin
        t = d - e - ci; u = (t + 512) % 256; c = (t < 0);
        v = ((d >= 128) != (e >= 128)) && ((u >= 128) != (d >= 128));
      end
      13: begin u = (d * 2 + ci) % 256; c = (d >= 128); v = c ^ (u >= 128); end
      14: begin u = d / 2 + ci * 128; c = d % 2; v = c ^ (u >= 128); end
      default: begin u = d / 2 + (d >= 128 ? 128 : 0); c = d % 2; v = c ^ (u >= 128); end
    endcase
    return {(u >= 128) ? 1'b1 : 1'b0, (u == 0) ? 1'b1 : 1'b0,
            v[0], c[0], 8'(u)};
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s func=%0d d=%02h e=%02h sel=%0d cs=%0d actual=%03h expected=%03h",
               req, func, opd_d, opd_e, cin_sel, c_stored, got, exp);
    end
  endtask

  task automatic apply(input int d, input int e, input int f, input int sel, input int cs);
    @(posedge clk);
    #1;
    opd_d = 8'(d); opd_e = 8'(e); func = 4'(f); cin_sel = 2'(sel); c_stored = cs[0];
    @(negedge clk);
    check(tag_of(f), {flags, result}, ref_alu(d, e, f, sel, cs));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int corners[4] = '{0, 127, 128, 255};
    void'($urandom(32'd20240611));
    opd_d = '0; opd_e = '0; func = '0; cin_sel = '0; c_stored = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state inputs: code 0 gives zero result with only Z set (R11).
    @(negedge clk);
    check("R11", {flags, result}, 12'h400);

    // R1: every carry select with both stored flag values, seen through code 9 on D=0.
    for (int s = 0; s < 4; s++) begin
      for (int cs = 0; cs < 2; cs++) begin
        apply(0, 8'hA5, 9, s, cs);
        check("R1", {11'd0, result[0]}, {11'd0, ((s == 1) || (s == 2 && cs == 1) || (s == 3 && cs == 0)) ? 1'b1 : 1'b0});
      end
    end

    // R11: negative result sets N only (code 3 gives 0xFF).
    apply(0, 0, 3, 0, 0);
    check("R11", {8'd0, flags}, 12'h008);

    // R12: V and C remain 0 for constant, pass and logic codes even with carry asserted.
    for (int f = 0; f <= 8; f++) begin
      if (f != 5) begin
        apply(8'hFF, 8'hFF, f, 1, 1);
        check("R12", {10'd0, flags[1:0]}, 12'd0);
      end
    end

    // Directed corners: all codes, corner operands, all carry selects.
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int s = 0; s < 4; s++)
            apply(corners[i], corners[j], f, s, (i + j + s) % 2);

    // Random vectors.
    for (int n = 0; n < 4000; n++)
      apply($urandom % 256, $urandom % 256, $urandom % 16, $urandom % 4, $urandom % 2);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule